// File: doc/BRIEF.md
# Processor Low-Power State Controller

This block sequences a processor core through three power levels: Running, Stop-Grant and Sleep. The system raises an active-low stop-clock request to take the core down to Stop-Grant. The core clocks are then gated off. The front-side-bus and interrupt-controller clocks keep running, so snoops and interrupts are still served. From Stop-Grant only, an active-low sleep request takes the core further down to Sleep. In Sleep every internal clock enable is off and neither snoops nor interrupts are accepted.

Both requests arrive asynchronously and each passes through a synchronizer of `SYNC_STAGES` flops before the state machine acts on it. The outputs are three clock-enable lines, two acceptance qualifiers for snoops and interrupts, and a one-cycle pulse. The pulse asks the bus unit to issue a Stop-Grant acknowledge transaction. Gating cells, the PLL and the bus encoding of the acknowledge belong to neighbouring blocks. Reset is asserted asynchronously and active-low, and its release is expected to be synchronous to `clk`.

Top module: `pwr_state_ctrl`

## Requirements
- R1: While `rst_n` is low and afterwards until a request takes effect, the state is Running: `core_clk_en`, `bus_clk_en`, `apic_clk_en`, `snoop_ok` and `intr_ok` are 1 and `sg_ack_req` is 0.
- R2: A request level present at rising edge k of `clk` decides the state transition at edge k+`SYNC_STAGES` (default 2). The outputs follow in that same cycle.
- R3: In Running with the stop-clock request low (asserted), the block enters Stop-Grant. `sg_ack_req` is 1 for exactly the first Stop-Grant cycle. This also holds when the sleep request is already low.
- R4: In Stop-Grant, `core_clk_en` is 0 while `bus_clk_en`, `apic_clk_en`, `snoop_ok` and `intr_ok` are 1.
- R5: In Stop-Grant with the stop-clock request still low and the sleep request low, the block enters Sleep. There all five enable and qualifier outputs are 0.
- R6: In Sleep, raising the sleep request returns the block to Stop-Grant, and `sg_ack_req` stays 0.
- R7: In Sleep, raising the stop-clock request has no effect while the sleep request stays low. The block stays in Sleep.
- R8: In Stop-Grant, raising the stop-clock request returns the block to Running with all outputs as in R1.
- R9: In Running, a low sleep request has no effect on any output.
- R10: In Stop-Grant, the stop-clock request may rise in the same cycle that the sleep request falls. The release wins, and the block returns to Running.
- R11: Driving `rst_n` low forces the Running outputs of R1 at once, from any state, without waiting for a clock edge.
- R12: `bus_clk_en` and `apic_clk_en` are never 0 while `core_clk_en` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset, asynchronous assertion |
| stop_req_n | input | 1 | Stop-clock request, active low, asynchronous |
| sleep_req_n | input | 1 | Sleep request, active low, asynchronous |
| core_clk_en | output | 1 | Clock enable for core units |
| bus_clk_en | output | 1 | Clock enable for the front-side-bus unit |
| apic_clk_en | output | 1 | Clock enable for the interrupt controller |
| sg_ack_req | output | 1 | One-cycle request for a Stop-Grant acknowledge transaction |
| snoop_ok | output | 1 | Snoops may be accepted |
| intr_ok | output | 1 | Interrupts may be accepted |

## Verification
Two events can land in the same synchronized cycle while the block is in Stop-Grant: the stop-clock release and the sleep assertion. The bench flips both request pins at one falling edge, so both reach the state machine together. The block is judged right if it leaves Stop-Grant for Running and never passes through Sleep. A second overlap has the sleep request already held low when the stop-clock request arrives. Here the acknowledge pulse must still appear for one cycle before the next cycle moves the block to Sleep.

// File: rtl/lpc_pkg.sv
package lpc_pkg;
  typedef enum logic [1:0] {
    LP_RUN   = 2'd0,
    LP_GRANT = 2'd1,
    LP_SLEEP = 2'd2
  } lp_state_e;
endpackage

// File: rtl/lpc_sync.sv
module lpc_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= RST_VAL;
        else        chain_q <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/lpc_fsm.sv
module lpc_fsm
  import lpc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      stop_act,
  input  logic      sleep_act,
  output lp_state_e state_q,
  output logic      ack_q
);
  lp_state_e state_d;
  logic      ack_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      LP_RUN:   if (stop_act) state_d = LP_GRANT;
      LP_GRANT: begin
        if (!stop_act)      state_d = LP_RUN;
        else if (sleep_act) state_d = LP_SLEEP;
      end
      LP_SLEEP: if (!sleep_act) state_d = LP_GRANT;
      default:  state_d = LP_RUN;
    endcase
    ack_d = (state_q == LP_RUN) && (state_d == LP_GRANT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LP_RUN;
      ack_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ack_q   <= ack_d;
    end
  end

  a_r3_ack_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |-> (state_q == LP_GRANT && $past(state_q) == LP_RUN));
  a_r3_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |=> !ack_q);
  a_r6_no_ack_from_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) == LP_SLEEP && state_q == LP_GRANT) |-> !ack_q);
  a_r7_sleep_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) == LP_SLEEP && $past(sleep_act)) |-> state_q == LP_SLEEP);
  a_r9_sleep_via_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == LP_SLEEP && $past(state_q) != LP_SLEEP) |-> $past(state_q) == LP_GRANT);
endmodule

// File: rtl/lpc_outdec.sv
module lpc_outdec
  import lpc_pkg::*;
(
  input  lp_state_e state,
  output logic      core_en,
  output logic      bus_en,
  output logic      apic_en,
  output logic      snoop_en,
  output logic      intr_en
);
  always_comb begin
    core_en  = 1'b0;
    bus_en   = 1'b0;
    apic_en  = 1'b0;
    snoop_en = 1'b0;
    intr_en  = 1'b0;
    unique case (state)
      LP_RUN: begin
        core_en  = 1'b1;
        bus_en   = 1'b1;
        apic_en  = 1'b1;
        snoop_en = 1'b1;
        intr_en  = 1'b1;
      end
      LP_GRANT: begin
        bus_en   = 1'b1;
        apic_en  = 1'b1;
        snoop_en = 1'b1;
        intr_en  = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pwr_state_ctrl.sv
module pwr_state_ctrl
  import lpc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stop_req_n,
  input  logic sleep_req_n,
  output logic core_clk_en,
  output logic bus_clk_en,
  output logic apic_clk_en,
  output logic sg_ack_req,
  output logic snoop_ok,
  output logic intr_ok
);
  logic      stop_n_s;
  logic      sleep_n_s;
  lp_state_e state;

  lpc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_stop (
    .clk(clk), .rst_n(rst_n), .d(stop_req_n), .q(stop_n_s)
  );
  lpc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sleep (
    .clk(clk), .rst_n(rst_n), .d(sleep_req_n), .q(sleep_n_s)
  );

  lpc_fsm u_fsm (
    .clk(clk), .rst_n(rst_n),
    .stop_act(~stop_n_s), .sleep_act(~sleep_n_s),
    .state_q(state), .ack_q(sg_ack_req)
  );

  lpc_outdec u_dec (
    .state(state),
    .core_en(core_clk_en), .bus_en(bus_clk_en), .apic_en(apic_clk_en),
    .snoop_en(snoop_ok), .intr_en(intr_ok)
  );

  a_r12_bus_drop_after_core: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_clk_en) |-> !$past(core_clk_en));
  a_r12_core_wakes_with_bus: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_clk_en) |-> $past(bus_clk_en) && bus_clk_en && apic_clk_en);
  a_r4_ack_in_grant: assert property (@(posedge clk) disable iff (!rst_n)
    sg_ack_req |-> (!core_clk_en && bus_clk_en && snoop_ok && intr_ok));
endmodule

// File: tb/pwr_state_ctrl_tb.sv
`timescale 1ns/1ps
module pwr_state_ctrl_tb;
  localparam int SYNC_STAGES = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stop_req_n = 1'b1;
  logic sleep_req_n = 1'b1;
  logic core_clk_en, bus_clk_en, apic_clk_en, sg_ack_req, snoop_ok, intr_ok;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  pwr_state_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_dut (
    .clk(clk), .rst_n(rst_n), .stop_req_n(stop_req_n), .sleep_req_n(sleep_req_n),
    .core_clk_en(core_clk_en), .bus_clk_en(bus_clk_en), .apic_clk_en(apic_clk_en),
    .sg_ack_req(sg_ack_req), .snoop_ok(snoop_ok), .intr_ok(intr_ok)
  );

  // reference model: 0 running, 1 stop-grant, 2 sleep
  logic [1:0] hist[$];
  int  m_st = 0;
  bit  m_ack = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist.delete();
      m_st = 0;
      m_ack = 0;
    end else begin
      logic [1:0] eff;
      bit stop_on, slp_on;
      hist.push_back({stop_req_n, sleep_req_n});
      m_ack = 0;
      if (hist.size() > SYNC_STAGES) begin
        eff = hist.pop_front();
        stop_on = !eff[1];
        slp_on  = !eff[0];
        if (m_st == 0) begin
          if (stop_on) begin m_st = 1; m_ack = 1; end
        end else if (m_st == 1) begin
          if (!stop_on) m_st = 0;
          else if (slp_on) m_st = 2;
        end else begin
          if (!slp_on) m_st = 1;
        end
      end
    end
  end

  task automatic compare(string tag);
    logic [5:0] got, exp;
    got = {core_clk_en, bus_clk_en, apic_clk_en, snoop_ok, intr_ok, sg_ack_req};
    exp = {m_st == 0, m_st != 2, m_st != 2, m_st != 2, m_st != 2, m_ack};
    n_cmp++;
    if (got[0] !== exp[0]) begin
      n_bad++;
      $display("FAIL R3 sg_ack_req actual=%b expected=%b t=%0t", got[0], exp[0], $time);
    end
    if (got[5:1] !== exp[5:1]) begin
      n_bad++;
      $display("FAIL %s enables actual=%b expected=%b t=%0t", tag, got[5:1], exp[5:1], $time);
    end
    if (core_clk_en === 1'b1 && (bus_clk_en !== 1'b1 || apic_clk_en !== 1'b1)) begin
      n_bad++;
      $display("FAIL R12 core on with bus/apic actual=%b%b expected=11", bus_clk_en, apic_clk_en);
    end
  endtask

  always @(negedge clk) if (!done) compare(cur_req);

  task automatic drive(bit stop_n, bit sleep_n, string tag, int cycles);
    @(negedge clk); #0.5;
    stop_req_n = stop_n;
    sleep_req_n = sleep_n;
    cur_req = tag;
    repeat (cycles) @(posedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk); #0.5 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    // R9: sleep while running ignored
    drive(1, 0, "R9", 6);
    drive(1, 1, "R9", 4);
    // R2 latency and R3 entry, then R4 hold
    drive(0, 1, "R2", 3);
    cur_req = "R4";
    repeat (5) @(posedge clk);
    // R5 into sleep
    drive(0, 0, "R5", 6);
    // R7 stop release ignored in sleep
    drive(1, 0, "R7", 6);
    drive(0, 0, "R7", 3);
    // R6 back to stop-grant, no acknowledge
    drive(0, 1, "R6", 6);
    // R8 back to running
    drive(1, 1, "R8", 6);
    // R10 collision
    drive(0, 1, "R4", 6);
    drive(1, 0, "R10", 6);
    drive(1, 1, "R10", 4);
    // R3 entry with sleep already held
    drive(1, 0, "R9", 4);
    drive(0, 0, "R3", 8);
    // R11 async reset from sleep
    @(posedge clk); #1;
    cur_req = "R11";
    rst_n = 1'b0;
    #0.5;
    n_cmp++;
    if ({core_clk_en, bus_clk_en, apic_clk_en, snoop_ok, intr_ok, sg_ack_req} !== 6'b111110) begin
      n_bad++;
      $display("FAIL R11 async reset actual=%b expected=111110",
               {core_clk_en, bus_clk_en, apic_clk_en, snoop_ok, intr_ok, sg_ack_req});
    end
    stop_req_n = 1'b1;
    sleep_req_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); #0.5 rst_n = 1'b1;
    cur_req = "R1";
    repeat (4) @(posedge clk);
    @(negedge clk); #1;
    finish_run();
  end
endmodule